// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. It takes one command at a time from a valid/ready request port and turns it into a serial frame on chip select, serial clock and serial data out. The command can be a read, a word write, a word erase, a program enable, a program disable, a fill of the whole array with one word, or a clear of the whole array. For reads it collects the returned bits from the device's data line. The block pulses a single response carrying the read word and a timeout flag.

The serial clock rate and the minimum chip-select low time are parameters counted in system clock cycles. The block sends a programming command and then drops chip select for the minimum low time. It raises chip select again and polls the device's ready line until the line reads 1, or until a cycle limit runs out. One input per command selects a 16-bit or an 8-bit word organization. That choice sets the address width and the data width of the frame. The controller keeps no record of whether programming is enabled. It sends whatever it is asked to send.

Top module: `eeprom3w_host`

## Requirements
- R1: `cmd_ready` is high only while the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low on the cycle after. Each accepted command produces exactly one single-cycle `rsp_valid` pulse.
- R2: A frame is sent while `ee_cs` is high, with `ee_di` sampled by the device on each `ee_sk` rising edge. It consists of a 1, then a 2-bit opcode, then the address MSB first. The opcodes are read = 10, write = 01 and erase = 11. The address has `AW16` bits (taken from the low bits of `cmd_addr`) when `cmd_org16` = 1, and `AW16`+1 bits when `cmd_org16` = 0.
- R3: The four array-wide commands use opcode 00. Their sub-code goes in the two most significant address bits: enable = 11, clear = 10, fill = 01, disable = 00. All lower address bits are sent as 0 and are still clocked. `cmd_op` codes are 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 fill, 6 clear. Code 7 produces the disable frame.
- R4: Write and fill frames append the data after the address, MSB first. The data is 16 bits of `cmd_wdata` in 16-bit mode, or `cmd_wdata[7:0]` in 8-bit mode.
- R5: A read frame adds as many further clock pulses as there are data bits (DI low). Every bit on `ee_do` is sampled at a falling `ee_sk` edge. The leading 0 the device emits at the last address pulse is discarded. `rsp_rdata` returns the data MSB-first: 16 bits, or 8 bits in [7:0] with [15:8] = 0. It is 0 for every other command.
- R6: During a frame, each `ee_sk` high phase and each low phase (including the one from the `ee_cs` rise to the first `ee_sk` rise) lasts exactly `HALF_CYC` cycles. `ee_sk` is high only while `ee_cs` is high, and `ee_di` does not change while `ee_sk` is high.
- R7: Before every rise of `ee_cs`, `ee_cs` has been low for at least `CS_LOW` cycles.
- R8: After a write, erase, fill or clear frame, `ee_cs` goes low for the minimum time and then high again with no `ee_sk` pulses. The response is given only once `ee_do` reads 1.
- R9: If `ee_do` does not read 1 within `POLL_LIMIT` cycles of the poll starting, the block ends the command. In that case `rsp_timeout` = 1 with `rsp_valid`. `rsp_timeout` is otherwise 0.
- R10: Read, enable and disable commands raise `ee_cs` once only, and they respond without polling.
- R11: After reset, `ee_cs`, `ee_sk`, `ee_di` and `rsp_valid` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_op | input | 3 | Command code (see R3) |
| cmd_addr | input | AW16+1 | Word address |
| cmd_wdata | input | 16 | Write or fill data |
| cmd_org16 | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| rsp_timeout | output | 1 | Ready poll expired |
| ee_cs | output | 1 | Chip select to device |
| ee_sk | output | 1 | Serial clock to device |
| ee_di | output | 1 | Serial data to device |
| ee_do | input | 1 | Serial data / ready from device |

## Verification
A wrong pulse count or a misloaded frame register shows up in the same command. The device sees a frame of the wrong length or the wrong bit pattern. Any extra clock pulse in the poll phase is taken as a fresh, short frame. A sampling-phase or synchronizer error shows up at the response of the first read, as a word shifted by one bit or carrying the dummy 0. A poll state that misses the ready level only becomes visible after `POLL_LIMIT` cycles, as a spurious timeout. The bench therefore counts chip-select rises and checks the timeout flag on every programming command.

// File: rtl/eeprom3w_pkg.sv
// Shared command and state types for the three-wire EEPROM host.
package eeprom3w_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_WEN   = 3'd3,
        CMD_WDIS  = 3'd4,
        CMD_FILL  = 3'd5,
        CMD_CLEAR = 3'd6,
        CMD_SPARE = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP,
        ST_POLL
    } state_e;

    // True for commands that start a self-timed programming cycle.
    function automatic logic is_prog(cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_FILL) || (c == CMD_CLEAR);
    endfunction

endpackage

// File: rtl/eeprom3w_halftick.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF_CYC cycles while en is high, with the
// first tick HALF_CYC cycles after en rises. Assumes HALF_CYC >= 3.
module eeprom3w_halftick #(
    parameter int HALF_CYC = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(HALF_CYC + 1);

    logic [TW-1:0] cnt;

    // Free-running phase counter, cleared whenever the generator is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (cnt == TW'(HALF_CYC - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == TW'(HALF_CYC - 1));

    // R6
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/eeprom3w_frame.sv
// Combinational frame builder.
// Produces the left-aligned outgoing bit string (start bit, opcode, address
// field, optional data) and the total number of serial clock pulses.
// Assumes AW16 >= 3.
module eeprom3w_frame
    import eeprom3w_pkg::*;
#(
    parameter int AW16 = 6,
    parameter int NW   = 5
) (
    input  cmd_e              op,
    input  logic [AW16:0]     addr,
    input  logic [15:0]       wdata,
    input  logic              org16,
    output logic [AW16+19:0]  frame,
    output logic [NW-1:0]     npulse
);
    localparam int AW8 = AW16 + 1;

    logic [1:0]      opc, sub;
    logic            special, has_data, is_read;
    logic [AW16-1:0] field16;
    logic [AW8-1:0]  field8;
    logic [15:0]     d16;
    logic [7:0]      d8;
    int              abits, dbits;

    // Decode opcode, array-wide sub-code and payload presence.
    always_comb begin
        opc = 2'b00; sub = 2'b00; special = 1'b0; has_data = 1'b0; is_read = 1'b0;
        unique case (op)
            CMD_READ:  begin opc = 2'b10; is_read = 1'b1; end
            CMD_WRITE: begin opc = 2'b01; has_data = 1'b1; end
            CMD_ERASE: opc = 2'b11;
            CMD_WEN:   begin special = 1'b1; sub = 2'b11; end
            CMD_FILL:  begin special = 1'b1; sub = 2'b01; has_data = 1'b1; end
            CMD_CLEAR: begin special = 1'b1; sub = 2'b10; end
            default:   begin special = 1'b1; sub = 2'b00; end
        endcase
    end

    // Assemble the bit string for the selected organization.
    always_comb begin
        field16 = special ? {sub, {(AW16 - 2){1'b0}}} : addr[AW16-1:0];
        field8  = special ? {sub, {(AW8 - 2){1'b0}}}  : addr;
        d16     = has_data ? wdata : 16'h0000;
        d8      = has_data ? wdata[7:0] : 8'h00;
        if (org16)
            frame = {1'b1, opc, field16, d16, 1'b0};
        else
            frame = {1'b1, opc, field8, d8, 8'h00};
        abits  = org16 ? AW16 : AW8;
        dbits  = org16 ? 16 : 8;
        npulse = NW'(3 + abits + ((has_data || is_read) ? dbits : 0));
    end

endmodule

// File: rtl/eeprom3w_host.sv
// Three-wire serial EEPROM host controller (top).
// Accepts one command when idle, shifts the frame out MSB first with a
// HALF_CYC-cycle serial clock phase, samples ee_do at every falling edge,
// polls ready after programming commands and pulses one response.
// Assumes HALF_CYC >= 3 (two-flop input synchronizer) and CS_LOW >= 1.
module eeprom3w_host
    import eeprom3w_pkg::*;
#(
    parameter int AW16       = 6,
    parameter int HALF_CYC   = 63,
    parameter int CS_LOW     = 63,
    parameter int POLL_LIMIT = 1_500_000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    output logic           cmd_ready,
    input  logic [2:0]     cmd_op,
    input  logic [AW16:0]  cmd_addr,
    input  logic [15:0]    cmd_wdata,
    input  logic           cmd_org16,
    output logic           rsp_valid,
    output logic [15:0]    rsp_rdata,
    output logic           rsp_timeout,
    output logic           ee_cs,
    output logic           ee_sk,
    output logic           ee_di,
    input  logic           ee_do
);
    localparam int FW  = AW16 + 20;
    localparam int NW  = $clog2(FW + 1);
    localparam int CW  = $clog2(POLL_LIMIT + CS_LOW + 1);
    localparam int LRW = $clog2(CS_LOW + 1) + 1;

    state_e         st;
    cmd_e           op_q;
    logic [AW16:0]  addr_q;
    logic [15:0]    wdata_q;
    logic           org_q;
    logic [FW-1:0]  frame_nx, sr;
    logic [NW-1:0]  npulse_nx, left;
    logic [CW-1:0]  cnt;
    logic [15:0]    rx, rx_nx;
    logic [1:0]     do_meta;
    logic           do_s, tick;

    eeprom3w_frame #(.AW16(AW16), .NW(NW)) u_frame (
        .op(op_q), .addr(addr_q), .wdata(wdata_q), .org16(org_q),
        .frame(frame_nx), .npulse(npulse_nx)
    );

    eeprom3w_halftick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(st == ST_SHIFT), .tick(tick)
    );

    // Bring the device data line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) do_meta <= 2'b00;
        else        do_meta <= {do_meta[0], ee_do};
    end

    assign do_s      = do_meta[1];
    assign rx_nx     = {rx[14:0], do_s};
    assign cmd_ready = (st == ST_IDLE);
    assign ee_di     = sr[FW-1];

    // Command sequencer: lead gap, shift, optional gap and ready poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; op_q <= CMD_READ; addr_q <= '0; wdata_q <= '0; org_q <= 1'b0;
            sr <= '0; left <= '0; cnt <= '0; rx <= '0;
            ee_cs <= 1'b0; ee_sk <= 1'b0;
            rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_timeout <= 1'b0;
        end else begin
            rsp_valid   <= 1'b0;
            rsp_timeout <= 1'b0;
            unique case (st)
                ST_IDLE: if (cmd_valid) begin
                    op_q <= cmd_e'(cmd_op); addr_q <= cmd_addr;
                    wdata_q <= cmd_wdata; org_q <= cmd_org16;
                    cnt <= '0; st <= ST_LEAD;
                end
                ST_LEAD: if (cnt == CW'(CS_LOW - 1)) begin
                    cnt <= '0; ee_cs <= 1'b1; sr <= frame_nx;
                    left <= npulse_nx; rx <= '0; st <= ST_SHIFT;
                end else cnt <= cnt + 1'b1;
                ST_SHIFT: if (tick) begin
                    if (!ee_sk) ee_sk <= 1'b1;
                    else begin
                        ee_sk <= 1'b0;
                        rx    <= rx_nx;
                        sr    <= {sr[FW-2:0], 1'b0};
                        if (left == NW'(1)) begin
                            ee_cs <= 1'b0; cnt <= '0;
                            if (is_prog(op_q)) st <= ST_GAP;
                            else begin
                                st <= ST_IDLE; rsp_valid <= 1'b1;
                                if (op_q != CMD_READ) rsp_rdata <= '0;
                                else rsp_rdata <= org_q ? rx_nx : {8'h00, rx_nx[7:0]};
                            end
                        end else left <= left - 1'b1;
                    end
                end
                ST_GAP: if (cnt == CW'(CS_LOW - 1)) begin
                    cnt <= '0; ee_cs <= 1'b1; st <= ST_POLL;
                end else cnt <= cnt + 1'b1;
                ST_POLL: if (cnt >= CW'(2) && do_s) begin
                    ee_cs <= 1'b0; st <= ST_IDLE; rsp_valid <= 1'b1; rsp_rdata <= '0;
                end else if (cnt == CW'(POLL_LIMIT - 1)) begin
                    ee_cs <= 1'b0; st <= ST_IDLE; rsp_valid <= 1'b1;
                    rsp_rdata <= '0; rsp_timeout <= 1'b1;
                end else cnt <= cnt + 1'b1;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Run length of chip select low, saturating, for the gap check.
    logic [LRW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n || ee_cs)                low_run <= '0;
        else if (low_run != LRW'(CS_LOW))   low_run <= low_run + 1'b1;
    end

    // R1
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !ee_cs);
    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R6
    sk_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);
    // R6
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
    // R7
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (low_run >= LRW'(CS_LOW)));
    // R9
    tmo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_valid);
    // R10
    poll_only_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POLL) |-> is_prog(op_q));

endmodule

// File: tb/eeprom3w_host_test.sv
// Scoreboard bench with a behavioural serial EEPROM model.
module eeprom3w_host_test;
    localparam int AW16 = 6, HALF = 4, CSL = 6, PLIM = 300, BUSY = 100;
    localparam int AW8 = AW16 + 1, NB = 1 << AW8;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic           cmd_valid = 1'b0, cmd_ready, cmd_org16 = 1'b1;
    logic [2:0]     cmd_op = 3'd0;
    logic [AW8-1:0] cmd_addr = '0;
    logic [15:0]    cmd_wdata = '0, rsp_rdata;
    logic           rsp_valid, rsp_timeout, ee_cs, ee_sk, ee_di, ee_do;

    eeprom3w_host #(.AW16(AW16), .HALF_CYC(HALF), .CS_LOW(CSL), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_org16(cmd_org16),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0, errors = 0, done_cnt = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0]  mem [NB] = '{default: 8'h00};
    logic        en_prog = 1'b0, stuck = 1'b0, rd_mode = 1'b0, rd_bit = 1'b0, busy;
    logic [15:0] rd_sr = '0;
    logic [63:0] rxb = '0, last_frame = '0;
    int          rxn = 0, last_len = 0, cs_rises = 0, prog_req = 0, prog_seen = 0, busy_left = 0;

    assign busy  = stuck || (busy_left > 0);
    assign ee_do = rd_mode ? rd_bit : !busy;

    always @(posedge ee_cs) begin
        rxn = 0; rxb = '0; rd_mode = 1'b0; cs_rises++;
    end

    always @(posedge ee_sk) if (ee_cs) begin
        int ab, a;
        ab  = cmd_org16 ? AW16 : AW8;
        rxb = {rxb[62:0], ee_di};
        rxn++;
        if (rd_mode) begin
            rd_bit = rd_sr[15];
            rd_sr  = rd_sr << 1;
        end else if (rxn == 3 + ab && rxb[ab+2] && rxb[ab+1 -: 2] == 2'b10) begin
            a = int'(rxb & ((64'd1 << ab) - 1));
            rd_mode = 1'b1; rd_bit = 1'b0;
            rd_sr = cmd_org16 ? {mem[2*a+1], mem[2*a]} : {mem[a], 8'h00};
        end
    end

    always @(negedge ee_cs) if (rxn > 0) begin
        int ab, dw, a, sub;
        logic [63:0] hdr, dat;
        logic [1:0]  op;
        last_frame = rxb; last_len = rxn;
        ab  = cmd_org16 ? AW16 : AW8;
        dw  = cmd_org16 ? 16 : 8;
        hdr = rxb >> (rxn - (3 + ab));
        op  = hdr[ab+1 -: 2];
        a   = int'(hdr & ((64'd1 << ab) - 1));
        sub = (a >> (ab - 2)) & 3;
        dat = rxb & ((64'd1 << dw) - 1);
        if (hdr[ab+2]) begin
            case (op)
                2'b00: case (sub)
                    3: en_prog = 1'b1;
                    0: en_prog = 1'b0;
                    2: if (en_prog) begin
                        for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
                        prog_req++;
                    end
                    default: if (en_prog && rxn == 3 + ab + dw) begin
                        for (int i = 0; i < NB; i++)
                            mem[i] = (cmd_org16 && i[0]) ? dat[15:8] : dat[7:0];
                        prog_req++;
                    end
                endcase
                2'b01: if (en_prog && rxn == 3 + ab + dw) begin
                    if (cmd_org16) begin mem[2*a] = dat[7:0]; mem[2*a+1] = dat[15:8]; end
                    else mem[a] = dat[7:0];
                    prog_req++;
                end
                2'b11: if (en_prog) begin
                    if (cmd_org16) begin mem[2*a] = 8'hFF; mem[2*a+1] = 8'hFF; end
                    else mem[a] = 8'hFF;
                    prog_req++;
                end
                default: ;
            endcase
        end
    end

    always @(posedge clk) begin
        if (prog_req != prog_seen) begin prog_seen = prog_req; busy_left = BUSY; end
        else if (busy_left > 0) busy_left--;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] rd;
        logic        tmo;
        logic [63:0] frame;
        int          len;
        logic        prog;
        int          base;
        string       tag;
    } item_t;
    item_t q[$];

    // Expected frame from R2/R3/R4/R5, built bit by bit.
    function automatic void build(input logic [2:0] op, input logic [AW8-1:0] a, input logic [15:0] d,
                                  input logic org, output logic [63:0] f, output int n);
        int ab, dw;
        logic [1:0] opc, sub;
        logic spec, wd, rd, b;
        ab = org ? AW16 : AW8; dw = org ? 16 : 8;
        opc = 2'b00; sub = 2'b00; spec = 1'b0; wd = 1'b0; rd = 1'b0;
        case (op)
            3'd0: begin opc = 2'b10; rd = 1'b1; end
            3'd1: begin opc = 2'b01; wd = 1'b1; end
            3'd2: opc = 2'b11;
            3'd3: begin spec = 1'b1; sub = 2'b11; end
            3'd5: begin spec = 1'b1; sub = 2'b01; wd = 1'b1; end
            3'd6: begin spec = 1'b1; sub = 2'b10; end
            default: begin spec = 1'b1; sub = 2'b00; end
        endcase
        f = {63'd0, 1'b1}; n = 1;
        f = {f[61:0], opc}; n += 2;
        for (int i = ab - 1; i >= 0; i--) begin
            if (spec) b = (i == ab - 1) ? sub[1] : (i == ab - 2) ? sub[0] : 1'b0;
            else      b = a[i];
            f = {f[62:0], b}; n++;
        end
        if (wd) for (int i = dw - 1; i >= 0; i--) begin f = {f[62:0], d[i]}; n++; end
        if (rd) for (int i = 0; i < dw; i++) begin f = {f[62:0], 1'b0}; n++; end
    endfunction

    task automatic do_cmd(input logic [2:0] op, input logic [AW8-1:0] a, input logic [15:0] d,
                          input logic org, input logic [15:0] exp_rd, input logic exp_tmo, input string tag);
        item_t it;
        int target;
        build(op, a, d, org, it.frame, it.len);
        it.rd = exp_rd; it.tmo = exp_tmo; it.tag = tag;
        it.prog = (op == 3'd1) || (op == 3'd2) || (op == 3'd5) || (op == 3'd6);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        it.base = cs_rises;
        q.push_back(it);
        target = done_cnt + 1;
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_org16 = org; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1", "busy after accept", {63'd0, cmd_ready}, 64'd0);
        wait (done_cnt >= target);
    endtask

    always @(negedge clk) if (rst_n && rsp_valid) begin
        item_t it;
        if (q.size() == 0) chk("R1", "unexpected response", 64'd1, 64'd0);
        else begin
            it = q.pop_front();
            chk(it.tag, "rdata", {48'd0, rsp_rdata}, {48'd0, it.rd});
            chk(it.tag, "timeout R9", {63'd0, rsp_timeout}, {63'd0, it.tmo});
            chk(it.tag, "frame R2 R3 R4", last_frame, it.frame);
            chk(it.tag, "frame length", 64'(last_len), 64'(it.len));
            chk(it.tag, "cs rises R8 R10", 64'(cs_rises - it.base), it.prog ? 64'd2 : 64'd1);
            if (it.prog && !it.tmo) chk(it.tag, "device ready R8", {63'd0, busy}, 64'd0);
        end
        done_cnt++;
    end

    // Serial timing monitor for R6 and R7.
    logic p_sk = 1'b0, p_cs = 1'b0;
    int sk_run = 0, cs_low_run = 0, sk_bad = 0, sk_seen = 0, cs_bad = 0;
    always @(negedge clk) if (rst_n) begin
        if (ee_cs && !p_cs) begin
            if (cs_low_run < CSL) cs_bad++;
            sk_run = 1;
        end else if (ee_sk != p_sk) begin
            sk_seen++;
            if (sk_run != HALF) sk_bad++;
            sk_run = 1;
        end else sk_run++;
        cs_low_run = ee_cs ? 0 : cs_low_run + 1;
        p_sk = ee_sk; p_cs = ee_cs;
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11", "cs", {63'd0, ee_cs}, 64'd0);
        chk("R11", "sk", {63'd0, ee_sk}, 64'd0);
        chk("R11", "di", {63'd0, ee_di}, 64'd0);
        chk("R11", "ready", {63'd0, cmd_ready}, 64'd1);
        chk("R11", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_cmd(3'd3, 7'd0,   16'h0000, 1'b1, 16'h0000, 1'b0, "R3 R10 enable");
        do_cmd(3'd1, 7'd5,   16'hA5C3, 1'b1, 16'h0000, 1'b0, "R4 R8 write16");
        do_cmd(3'd0, 7'd5,   16'h0000, 1'b1, 16'hA5C3, 1'b0, "R2 R5 read16");
        do_cmd(3'd0, 7'd11,  16'h0000, 1'b0, 16'h00A5, 1'b0, "R5 read8 hi");
        do_cmd(3'd0, 7'd10,  16'h0000, 1'b0, 16'h00C3, 1'b0, "R5 read8 lo");
        do_cmd(3'd4, 7'd0,   16'h0000, 1'b1, 16'h0000, 1'b0, "R3 disable");
        do_cmd(3'd1, 7'd5,   16'h1234, 1'b1, 16'h0000, 1'b0, "R8 write while disabled");
        do_cmd(3'd0, 7'd5,   16'h0000, 1'b1, 16'hA5C3, 1'b0, "R5 read unchanged");
        do_cmd(3'd7, 7'd99,  16'hFFFF, 1'b0, 16'h0000, 1'b0, "R3 spare code");
        do_cmd(3'd3, 7'd0,   16'h0000, 1'b0, 16'h0000, 1'b0, "R3 enable8");
        do_cmd(3'd2, 7'd10,  16'h0000, 1'b0, 16'h0000, 1'b0, "R2 R8 erase8");
        do_cmd(3'd0, 7'd5,   16'h0000, 1'b1, 16'hA5FF, 1'b0, "R5 read after erase");
        do_cmd(3'd1, 7'd0,   16'h553C, 1'b0, 16'h0000, 1'b0, "R4 write8");
        do_cmd(3'd0, 7'd0,   16'h0000, 1'b0, 16'h003C, 1'b0, "R5 read8 written");
        do_cmd(3'd5, 7'd0,   16'h9E17, 1'b1, 16'h0000, 1'b0, "R3 R4 fill16");
        do_cmd(3'd0, 7'd63,  16'h0000, 1'b1, 16'h9E17, 1'b0, "R5 read top word");
        do_cmd(3'd0, 7'd127, 16'h0000, 1'b0, 16'h009E, 1'b0, "R5 read top byte");
        do_cmd(3'd6, 7'd0,   16'h0000, 1'b0, 16'h0000, 1'b0, "R3 R8 clear8");
        do_cmd(3'd0, 7'd0,   16'h0000, 1'b1, 16'hFFFF, 1'b0, "R5 read cleared");
        stuck = 1'b1;
        do_cmd(3'd1, 7'd1,   16'hBEEF, 1'b1, 16'h0000, 1'b1, "R9 stuck busy");
        stuck = 1'b0;
        repeat (BUSY + 10) @(negedge clk);
        do_cmd(3'd0, 7'd1,   16'h0000, 1'b1, 16'hBEEF, 1'b0, "R5 R9 read after timeout");

        repeat (20) @(negedge clk);
        chk("R6", "sk phase width errors", 64'(sk_bad), 64'd0);
        chk("R6", "sk edges seen", {63'd0, sk_seen > 0}, 64'd1);
        chk("R7", "cs low gap errors", 64'(cs_bad), 64'd0);
        chk("R1", "queue empty", 64'(q.size()), 64'd0);
        finish_run();
    end

endmodule